// File: doc/BRIEF.md
# Pointer-Chase Latency Measurement Engine

This engine measures how a memory behaves under strictly serial access. Software gives it a start index, a warm-up count and a measured-step count. The engine follows a chain in which every word read is the index of the next word to read. It first makes an unmeasured warm-up pass, which really issues every load so that the memory under test is filled before timing begins. It then makes the measured pass.

On each measured step the engine keeps two things in on-chip record buffers: the index that came back and the number of clock cycles the load took. The cycle count comes from a free-running 16-bit counter. The counter is sampled when the request is accepted and again when the data arrives. Because the next address is the returned data, no two loads can ever overlap, and the stop time can only be taken once the whole access has finished.

After the run, software reads the records through a one-cycle read port. The step count may be larger than the chain, in which case the chain is traversed several times. It may also be larger than the buffers; recording then stops at the buffer depth while the walk still runs to the end.

Top module: `ptr_chase_engine`

## Requirements
- R1: After reset, busy, done, req_valid and rec_count are all 0. A start pulse in idle makes busy 1 in the next cycle, and the first request carries start_idx.
- R2: Every request after the first carries the data of the previous response. A new request appears only after the previous response has arrived, so at most one load is outstanding.
- R3: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_addr does not change.
- R4: The engine issues exactly preheat_cnt warm-up loads before the measured loads. No warm-up load is recorded, and a run with iter_cnt of 0 leaves rec_count at 0.
- R5: The engine issues exactly iter_cnt measured loads. Measured step j writes its returned data to index-buffer entry j, in step order.
- R6: Latency-buffer entry j holds, modulo 2^16, the count of clock edges from the edge that accepted step j's request to the edge that sampled its response.
- R7: rec_count equals min(iter_cnt, DEPTH) at the end of a run and never exceeds DEPTH. Steps beyond DEPTH are still issued.
- R8: The cycle after the last response is sampled, busy is 0 and done is 1. done stays 1, and no request is issued, until the next accepted start.
- R9: A start pulse while busy is 1 is ignored: the walk in progress continues with its original arguments.
- R10: A start with iter_cnt and preheat_cnt both 0 issues no load. done is 1 and busy is 0 in the next cycle.
- R11: The record entry at rd_addr appears on rd_index and rd_latency one cycle after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_idx | input | IDX_W | First index of the chain |
| iter_cnt | input | CNT_W | Number of measured steps |
| preheat_cnt | input | CNT_W | Number of unmeasured warm-up steps |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk finished |
| req_valid | output | 1 | Load request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | IDX_W | Index to load |
| rsp_valid | input | 1 | Load data valid |
| rsp_data | input | IDX_W | Loaded word, which is the next index |
| rd_addr | input | $clog2(DEPTH) | Record entry to read |
| rd_index | output | IDX_W | Recorded index at rd_addr |
| rd_latency | output | LAT_W | Recorded latency at rd_addr |
| rec_count | output | $clog2(DEPTH)+1 | Number of entries recorded |

## Verification
The bench memory answers a request accepted at one edge by raising rsp_valid after d+1 further edges, where d is the index modulo 4. The engine samples that response one edge later, so the expected latency is d+2 cycles no matter how long the request stalled on req_ready beforehand. Request indices are compared at the cycle before each accepting edge, and busy/done are compared one cycle after a start or after the final response. Record entries are compared one cycle after rd_addr is driven. All samples are taken on the falling edge, so each expected value refers to a specific rising edge.

// File: rtl/ptr_chase_engine.sv
module ptr_chase_engine #(
  parameter int IDX_W = 32,
  parameter int CNT_W = 32,
  parameter int LAT_W = 16,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [IDX_W-1:0]         start_idx,
  input  logic [CNT_W-1:0]         iter_cnt,
  input  logic [CNT_W-1:0]         preheat_cnt,
  output logic                     busy,
  output logic                     done,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [IDX_W-1:0]         req_addr,
  input  logic                     rsp_valid,
  input  logic [IDX_W-1:0]         rsp_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [IDX_W-1:0]         rd_index,
  output logic [LAT_W-1:0]         rd_latency,
  output logic [$clog2(DEPTH):0]   rec_count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] CAP = (PTR_W+1)'(DEPTH);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t           state;
  logic [IDX_W-1:0] cur;
  logic [CNT_W-1:0] warm_left, meas_left;
  logic [LAT_W-1:0] tick, t_issue;
  logic [PTR_W:0]   wr_ptr;
  logic             done_q;

  logic [IDX_W-1:0] idx_buf [DEPTH];
  logic [LAT_W-1:0] lat_buf [DEPTH];

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign req_valid = (state == S_ISSUE);
  assign req_addr  = cur;
  assign rec_count = wr_ptr;

  wire accept  = req_valid && req_ready;
  wire arrived = (state == S_WAIT) && rsp_valid;
  wire warming = (warm_left != '0);
  wire final_step = warming ? (warm_left == ONE && meas_left == '0) : (meas_left == ONE);
  wire rec_en  = arrived && !warming && (wr_ptr < CAP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= '0;
    else        tick <= tick + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      warm_left <= '0;
      meas_left <= '0;
      t_issue   <= '0;
      wr_ptr    <= '0;
      done_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cur       <= start_idx;
          warm_left <= preheat_cnt;
          meas_left <= iter_cnt;
          wr_ptr    <= '0;
          if (preheat_cnt == '0 && iter_cnt == '0) begin
            done_q <= 1'b1;
          end else begin
            done_q <= 1'b0;
            state  <= S_ISSUE;
          end
        end
        S_ISSUE: if (accept) begin
          t_issue <= tick;
          state   <= S_WAIT;
        end
        S_WAIT: if (rsp_valid) begin
          cur <= rsp_data;
          if (warming) warm_left <= warm_left - ONE;
          else         meas_left <= meas_left - ONE;
          if (rec_en) wr_ptr <= wr_ptr + 1'b1;
          if (final_step) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rec_en) begin
      idx_buf[wr_ptr[PTR_W-1:0]] <= rsp_data;
      lat_buf[wr_ptr[PTR_W-1:0]] <= tick - t_issue;
    end
  end

  always_ff @(posedge clk) begin
    rd_index   <= idx_buf[rd_addr];
    rd_latency <= lat_buf[rd_addr];
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy || done);

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_valid);

  assert_chain_follows_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arrived |=> !busy || (req_valid && req_addr == $past(rsp_data)));

  assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  assert_records_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rec_count >= $past(rec_count));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= CAP);

  assert_busy_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rsp_valid |=> busy);
endmodule

// File: tb/ptr_chase_engine_tb_top.sv
`timescale 1ns/1ps
module ptr_chase_engine_tb_top;
  localparam int DEPTH = 1024;
  localparam int PW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [31:0]   start_idx = '0, iter_cnt = '0, preheat_cnt = '0;
  logic          busy, done, req_valid, req_ready, rsp_valid;
  logic [31:0]   req_addr, rsp_data, rd_index;
  logic [PW-1:0] rd_addr = '0;
  logic [15:0]   rd_latency;
  logic [PW:0]   rec_count;

  ptr_chase_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
    .iter_cnt(iter_cnt), .preheat_cnt(preheat_cnt), .busy(busy), .done(done),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_addr(rd_addr),
    .rd_index(rd_index), .rd_latency(rd_latency), .rec_count(rec_count));

  int n_checks = 0, n_fail = 0, cyc = 0;
  int len = 16, stride = 1;
  bit stall_mode = 1'b0;

  function automatic logic [31:0] nxt(input logic [31:0] a);
    return (a + 32'(stride)) % 32'(len);
  endfunction
  function automatic int lat_of(input logic [31:0] a);
    return 2 + int'(a % 4);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model: response d+1 edges after acceptance, d = index mod 4
  logic [31:0] m_addr = '0;
  int          m_cnt = 0;
  bit          m_pend = 1'b0;
  always_ff @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (m_pend) begin
      if (m_cnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= nxt(m_addr);
        m_pend    <= 1'b0;
      end else m_cnt <= m_cnt - 1;
    end
    if (req_valid && req_ready) begin
      m_pend <= 1'b1;
      m_cnt  <= int'(req_addr % 4);
      m_addr <= req_addr;
    end
  end
  initial rsp_data = '0;

  always @(posedge clk) begin
    cyc++;
    #1 req_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // scoreboard queues
  logic [31:0] addr_q[$];
  logic [31:0] idx_q[$];
  int          lat_q[$];
  int          hs_cnt = 0;
  int          hs_in_run = 0;

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      hs_cnt++;
      if (addr_q.size() == 0) chk(1'b0, "R2 extra load", int'(req_addr), -1);
      else begin
        logic [31:0] e;
        e = addr_q.pop_front();
        chk(req_addr == e, hs_in_run == 0 ? "R1 first address" : "R2 chained address",
            int'(req_addr), int'(e));
      end
      hs_in_run++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic readback();
    int n;
    n = int'(rec_count);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ei;
      int el;
      rd_addr = PW'(i);
      @(negedge clk);
      ei = idx_q.pop_front();
      el = lat_q.pop_front();
      chk(rd_index == ei, "R5 R11 recorded index", int'(rd_index), int'(ei));
      chk(int'(rd_latency) == el, "R6 recorded latency", int'(rd_latency), el);
    end
    chk(idx_q.size() == 0, "R7 entries left unread", idx_q.size(), 0);
    idx_q.delete(); lat_q.delete();
  endtask

  task automatic run_walk(input logic [31:0] s, input int p, input int k, input bit inject);
    logic [31:0] a;
    int base, exp_rec;
    a = s;
    for (int i = 0; i < p + k; i++) begin
      addr_q.push_back(a);
      if (i >= p && (i - p) < DEPTH) begin
        idx_q.push_back(nxt(a));
        lat_q.push_back(lat_of(a));
      end
      a = nxt(a);
    end
    base = hs_cnt;
    hs_in_run = 0;
    @(negedge clk);
    start = 1'b1; start_idx = s; iter_cnt = 32'(k); preheat_cnt = 32'(p);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    if (inject) begin
      repeat (6) @(negedge clk);
      start = 1'b1; start_idx = 32'd7; iter_cnt = 32'd2; preheat_cnt = 32'd0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after ignored start", int'(busy), 1);
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
    chk(hs_cnt - base == p + k, "R4 R5 total loads", hs_cnt - base, p + k);
    chk(addr_q.size() == 0, "R2 missing loads", addr_q.size(), 0);
    exp_rec = (k < DEPTH) ? k : DEPTH;
    chk(int'(rec_count) == exp_rec, "R7 rec_count", int'(rec_count), exp_rec);
    readback();
    base = hs_cnt;
    repeat (4) @(negedge clk);
    chk(done == 1'b1 && hs_cnt == base, "R8 done held, no loads", int'(done), 1);
  endtask

  initial begin
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && rec_count == 0, "R1 reset state",
        int'({busy, done, req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    len = 16; stride = 1; stall_mode = 1'b0;
    run_walk(32'd3, 16, 20, 1'b0);

    len = 32; stride = 5; stall_mode = 1'b1;
    run_walk(32'd1, 32, 40, 1'b0);

    len = 24; stride = 7; stall_mode = 1'b0;
    run_walk(32'd2, 5, 12, 1'b1);

    run_walk(32'd4, 0, 5, 1'b0);
    run_walk(32'd4, 3, 0, 1'b0);
    chk(rec_count == 0, "R4 warm-up only records nothing", int'(rec_count), 0);

    begin
      int base;
      base = hs_cnt;
      @(negedge clk);
      start = 1'b1; start_idx = 32'd5; iter_cnt = '0; preheat_cnt = '0;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1 && busy == 1'b0, "R10 empty run done", int'(done), 1);
      repeat (3) @(negedge clk);
      chk(hs_cnt == base, "R10 no loads issued", hs_cnt - base, 0);
    end

    len = 64; stride = 8; stall_mode = 1'b1;
    run_walk(32'd0, 10, DEPTH + 6, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule